// File: doc/BRIEF.md
# Single-Accumulator Stored-Program Processor

This block is a very small processor that runs programs held in one shared memory. Instructions and data both live in that memory, and each location holds one 16-bit word. Every instruction passes through three steps in a fixed loop. In fetch, the word at the program counter is read into the instruction register. In execute, the operation is carried out. In increment, the program counter moves forward by one. The loop repeats until a halt instruction is executed.

An instruction word holds a 4-bit operation code in its top bits and a 12-bit direct operand address in its low bits. Data words are read as two's-complement values: a sign bit above 15 magnitude bits. The only working register is the accumulator. Three operations use it: load it from memory, add a memory word to it, and store it to memory.

The block drives a single-port synchronous memory. A read returns its data one cycle after the address is presented. For observation, the accumulator, program counter, instruction register and a halt flag are brought out as ports.

Top module: `acc_cpu`

## Requirements
- R1: While rst_n is low at a clock edge, the accumulator and instruction register clear to 0, the program counter takes start_addr, halted is 0 and mem_we is 0.
- R2: In the first cycle after reset is released, mem_addr equals the program counter. The instruction register takes the memory word at that address at the end of the following cycle, so it shows the new word two cycles after release.
- R3: Opcode 1 in bits 15:12 (load) replaces the accumulator with the memory word at the address in bits 11:0.
- R4: Opcode 5 (add) adds the memory word at the operand address to the accumulator. The result wraps modulo 2^16 (0x7FFF+1 gives 0x8000, and 0x8000+0x8000 gives 0).
- R5: Opcode 2 (store) raises mem_we for exactly one cycle, with mem_addr equal to the operand address and mem_wdata equal to the accumulator.
- R6: The program counter changes only in the increment step, which follows execute, and only by +1. It holds its value through fetch and execute.
- R7: Opcode 0 (halt) sets halted. From then until reset the program counter does not change, mem_we stays 0 and halted stays 1.
- R8: Every other opcode (3, 4 and 6 to 15) leaves the accumulator and memory unchanged and still advances the program counter by one.
- R9: mem_we is asserted only while the instruction register holds a store.
- R10: The program load [940], add [941], store [941] placed at 300 to 302, with 3 at 940 and 2 at 941, leaves 5 at location 941.
- R11: The program counter wraps from 4095 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_addr | input | 12 | Address of the first instruction, taken during reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| ir_o | output | 16 | Instruction register |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
A wrong sequencer state shows up as a misplaced memory address within one cycle. A one-cycle slip in read-data capture puts a stale word into the instruction register or the accumulator, and that shows at acc_o two cycles after the operand address appears. A bad decode shows either as a write strobe during a non-store, which the scoreboard flags in the cycle it happens, or as a wrong value in the final memory image. A program counter that skips or stalls moves the halt point, so pc_o at halt differs from start address plus instruction count.

// File: rtl/acc_pkg.sv
// Shared constants and types for the accumulator processor.
// Assumes an instruction word is exactly opcode bits plus address bits wide.
package acc_pkg;
    localparam int OP_HALT  = 0;
    localparam int OP_LOAD  = 1;
    localparam int OP_STORE = 2;
    localparam int OP_ADD   = 5;

    // Sequencer steps: two cycles per memory read, then the increment step
    typedef enum logic [2:0] {
        ST_FETCH_ADDR = 3'd0,
        ST_FETCH_DATA = 3'd1,
        ST_EXEC       = 3'd2,
        ST_EXEC_DATA  = 3'd3,
        ST_INCR       = 3'd4,
        ST_HALT       = 3'd5
    } step_t;
endpackage

// File: rtl/acc_alu.sv
// Accumulator arithmetic: passes the memory word through for a load or adds it
// to the accumulator for an add. Assumes that a wrap modulo 2^DW is the intended overflow.
module acc_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] acc_in,
    input  logic [DW-1:0] mem_in,
    input  logic          add_en,
    output logic [DW-1:0] result
);
    // Select the pass-through or the sum
    always_comb begin
        result = add_en ? DW'(acc_in + mem_in) : mem_in;
    end
endmodule

// File: rtl/acc_ctrl.sv
// Control sequencer. It steps fetch (address, data), execute, optional operand
// data capture and increment, and decodes the opcode held in the instruction
// register. Assumes the memory returns read data one cycle after the address.
module acc_ctrl
    import acc_pkg::*;
#(
    parameter int OPW = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [OPW-1:0] opcode,
    output logic           ir_load,
    output logic           acc_load,
    output logic           acc_add,
    output logic           pc_inc,
    output logic           mem_we,
    output logic           addr_pc,
    output logic           halted
);
    step_t st, st_nx;

    logic is_load, is_add, is_store, is_halt;

    // Opcode decode
    always_comb begin
        is_load  = (opcode == OPW'(OP_LOAD));
        is_add   = (opcode == OPW'(OP_ADD));
        is_store = (opcode == OPW'(OP_STORE));
        is_halt  = (opcode == OPW'(OP_HALT));
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_FETCH_ADDR;
        else        st <= st_nx;
    end

    // Next step and control strobes
    always_comb begin
        st_nx    = st;
        ir_load  = 1'b0;
        acc_load = 1'b0;
        acc_add  = 1'b0;
        pc_inc   = 1'b0;
        mem_we   = 1'b0;
        addr_pc  = 1'b0;
        halted   = 1'b0;
        case (st)
            ST_FETCH_ADDR: begin
                addr_pc = 1'b1;
                st_nx   = ST_FETCH_DATA;
            end
            ST_FETCH_DATA: begin
                addr_pc = 1'b1;
                ir_load = 1'b1;
                st_nx   = ST_EXEC;
            end
            ST_EXEC: begin
                if (is_halt)                st_nx = ST_HALT;
                else if (is_load || is_add) st_nx = ST_EXEC_DATA;
                else begin
                    mem_we = is_store;
                    st_nx  = ST_INCR;
                end
            end
            ST_EXEC_DATA: begin
                acc_load = 1'b1;
                acc_add  = is_add;
                st_nx    = ST_INCR;
            end
            ST_INCR: begin
                pc_inc = 1'b1;
                st_nx  = ST_FETCH_ADDR;
            end
            ST_HALT: begin
                halted = 1'b1;
                st_nx  = ST_HALT;
            end
            default: st_nx = ST_FETCH_ADDR;
        endcase
    end
endmodule

// File: rtl/acc_regs.sv
// Architectural registers: program counter, instruction register and
// accumulator. Assumes the strobes from the sequencer are mutually timed so
// that each register is written in one step only.
module acc_regs #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_addr,
    input  logic          ir_load,
    input  logic          acc_load,
    input  logic          acc_add,
    input  logic          pc_inc,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] pc,
    output logic [DW-1:0] ir,
    output logic [DW-1:0] acc
);
    logic [DW-1:0] alu_y;

    acc_alu #(.DW(DW)) u_alu (
        .acc_in (acc),
        .mem_in (mem_rdata),
        .add_en (acc_add),
        .result (alu_y)
    );

    // Program counter: start address on reset, +1 in the increment step
    always_ff @(posedge clk) begin
        if (!rst_n)      pc <= start_addr;
        else if (pc_inc) pc <= AW'(pc + 1'b1);
    end

    // Instruction register: captures the fetched word
    always_ff @(posedge clk) begin
        if (!rst_n)       ir <= '0;
        else if (ir_load) ir <= mem_rdata;
    end

    // Accumulator: captures the load or add result
    always_ff @(posedge clk) begin
        if (!rst_n)        acc <= '0;
        else if (acc_load) acc <= alu_y;
    end
endmodule

// File: rtl/acc_cpu.sv
// Top of the single-accumulator processor. It joins the sequencer and the
// register file and steers the memory address between the program counter and
// the operand field. Assumes DW equals OPW plus AW and a one-cycle read latency.
module acc_cpu #(
    parameter int AW  = 12,
    parameter int OPW = 4,
    parameter int DW  = OPW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] start_addr,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] acc_o,
    output logic [AW-1:0] pc_o,
    output logic [DW-1:0] ir_o,
    output logic          halted
);
    localparam int OP_MSB = DW - 1;

    logic ir_load, acc_load, acc_add, pc_inc, addr_pc;

    acc_ctrl #(.OPW(OPW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (ir_o[OP_MSB -: OPW]),
        .ir_load  (ir_load),
        .acc_load (acc_load),
        .acc_add  (acc_add),
        .pc_inc   (pc_inc),
        .mem_we   (mem_we),
        .addr_pc  (addr_pc),
        .halted   (halted)
    );

    acc_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .ir_load    (ir_load),
        .acc_load   (acc_load),
        .acc_add    (acc_add),
        .pc_inc     (pc_inc),
        .mem_rdata  (mem_rdata),
        .pc         (pc_o),
        .ir         (ir_o),
        .acc        (acc_o)
    );

    // Memory address and write data steering
    always_comb begin
        mem_addr  = addr_pc ? pc_o : ir_o[AW-1:0];
        mem_wdata = acc_o;
    end
endmodule

// File: rtl/acc_cpu_chk.sv
// Port-level property checker for acc_cpu, attached by bind.
module acc_cpu_chk
    import acc_pkg::*;
#(
    parameter int AW  = 12,
    parameter int OPW = 4,
    parameter int DW  = OPW + AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_we,
    input logic [DW-1:0] acc_o,
    input logic [AW-1:0] pc_o,
    input logic [DW-1:0] ir_o,
    input logic          halted
);
    logic [OPW-1:0] op;
    assign op = ir_o[DW-1 -: OPW];

    // R9
    we_only_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (op == OPW'(OP_STORE)));

    // R5
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R6
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_o != $past(pc_o)) |-> (pc_o == AW'($past(pc_o) + 1'b1)));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_o) && !mem_we));

    // R7
    halt_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (op == OPW'(OP_HALT)));

    // R8
    acc_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_o != $past(acc_o)) |-> (op == OPW'(OP_LOAD) || op == OPW'(OP_ADD)));
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .OPW(OPW), .DW(DW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mem_we (mem_we),
    .acc_o  (acc_o),
    .pc_o   (pc_o),
    .ir_o   (ir_o),
    .halted (halted)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int MEM_WORDS = 1 << AW;
    localparam int RUN_LIMIT = 2000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] acc_o;
    logic [AW-1:0] pc_o;
    logic [DW-1:0] ir_o;
    logic          halted;

    logic [DW-1:0] mem [MEM_WORDS];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct packed {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
    } wr_t;
    wr_t exp_q[$];
    wr_t mon_e;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_we     (mem_we),
        .mem_rdata  (mem_rdata),
        .acc_o      (acc_o),
        .pc_o       (pc_o),
        .ir_o       (ir_o),
        .halted     (halted)
    );

    // Synchronous single-port memory, one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected store
    task automatic expect_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_t e;
        e.a = a;
        e.d = d;
        exp_q.push_back(e);
    endtask

    // Monitor: every write strobe is popped and compared
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                chk("R9", "write with none expected", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
                mon_e = exp_q.pop_front();
                chk("R5", "store address", 32'(mem_addr), 32'(mon_e.a));
                chk("R5", "store data", 32'(mem_wdata), 32'(mon_e.d));
            end
        end
    end

    task automatic clear_mem();
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
    endtask

    // Reset with a start address and check the reset state (R1)
    task automatic reset_to(input logic [AW-1:0] sa);
        rst_n = 1'b0;
        start_addr = sa;
        repeat (3) @(negedge clk);
        chk("R1", "acc after reset", 32'(acc_o), 32'h0);
        chk("R1", "ir after reset", 32'(ir_o), 32'h0);
        chk("R1", "pc after reset", 32'(pc_o), 32'(sa));
        chk("R1", "halted after reset", 32'(halted), 32'h0);
        chk("R1", "we after reset", 32'(mem_we), 32'h0);
    endtask

    task automatic wait_halt();
        int n = 0;
        while (!halted && n < RUN_LIMIT) begin
            @(negedge clk);
            n++;
        end
        chk("R7", "halt reached", 32'(halted), 32'h1);
        chk("R5", "stores outstanding", 32'(exp_q.size()), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk("WDOG", "watchdog expired", 32'h0, 32'h1);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end

    initial begin
        // Test 1: the three-instruction example with step timing (R2 R3 R4 R6 R10)
        clear_mem();
        mem[300] = 16'h13AC;
        mem[301] = 16'h53AD;
        mem[302] = 16'h23AD;
        mem[303] = 16'h0000;
        mem[940] = 16'd3;
        mem[941] = 16'd2;
        expect_store(12'd941, 16'd5);
        reset_to(12'd300);
        rst_n = 1'b1;
        chk("R2", "fetch address", 32'(mem_addr), 32'd300);
        @(negedge clk);
        chk("R2", "ir before capture", 32'(ir_o), 32'h0);
        @(negedge clk);
        chk("R2", "ir captured", 32'(ir_o), 32'h13AC);
        chk("R3", "operand address", 32'(mem_addr), 32'd940);
        chk("R6", "pc held in execute", 32'(pc_o), 32'd300);
        @(negedge clk);
        @(negedge clk);
        chk("R3", "acc after load", 32'(acc_o), 32'd3);
        chk("R6", "pc before increment", 32'(pc_o), 32'd300);
        @(negedge clk);
        chk("R6", "pc after increment", 32'(pc_o), 32'd301);
        wait_halt();
        chk("R10", "result at 941", 32'(mem[941]), 32'd5);
        chk("R4", "acc after add", 32'(acc_o), 32'd5);
        chk("R7", "pc at halt", 32'(pc_o), 32'd303);
        repeat (20) @(negedge clk);
        chk("R7", "pc frozen", 32'(pc_o), 32'd303);
        chk("R7", "still halted", 32'(halted), 32'h1);

        // Test 2: add wrap and negative values (R4)
        clear_mem();
        mem[12'h010] = 16'h1100;
        mem[12'h011] = 16'h5101;
        mem[12'h012] = 16'h2200;
        mem[12'h013] = 16'h5102;
        mem[12'h014] = 16'h2201;
        mem[12'h015] = 16'h1103;
        mem[12'h016] = 16'h5103;
        mem[12'h017] = 16'h2202;
        mem[12'h018] = 16'h0000;
        mem[12'h100] = 16'h7FFF;
        mem[12'h101] = 16'h0001;
        mem[12'h102] = 16'h8000;
        mem[12'h103] = 16'hFFFF;
        expect_store(12'h200, 16'h8000);
        expect_store(12'h201, 16'h0000);
        expect_store(12'h202, 16'hFFFE);
        reset_to(12'h010);
        rst_n = 1'b1;
        wait_halt();
        chk("R4", "0x7FFF+1", 32'(mem[12'h200]), 32'h8000);
        chk("R4", "0x8000+0x8000", 32'(mem[12'h201]), 32'h0);
        chk("R4", "-1 + -1", 32'(mem[12'h202]), 32'hFFFE);
        chk("R7", "pc at halt", 32'(pc_o), 32'h018);

        // Test 3: undefined opcodes act as no-operations (R8)
        clear_mem();
        begin
            int k = 0;
            mem[12'h400] = 16'h1500;
            k = 1;
            for (int op = 3; op < 16; op++) begin
                if (op != 5) begin
                    mem[12'h400 + k] = 16'(op << 12) | 16'h0501;
                    k++;
                end
            end
            mem[12'h400 + k] = 16'h2502;
            mem[12'h400 + k + 1] = 16'h0000;
            mem[12'h500] = 16'h1234;
            mem[12'h501] = 16'hBEEF;
            expect_store(12'h502, 16'h1234);
            reset_to(12'h400);
            rst_n = 1'b1;
            wait_halt();
            chk("R8", "acc kept", 32'(acc_o), 32'h1234);
            chk("R8", "operand untouched", 32'(mem[12'h501]), 32'hBEEF);
            chk("R8", "stored value", 32'(mem[12'h502]), 32'h1234);
            chk("R8", "pc at halt", 32'(pc_o), 32'(12'h400 + k + 1));
        end

        // Test 4: program counter wrap (R11)
        clear_mem();
        mem[12'hFFF] = 16'h4000;
        mem[12'h000] = 16'h0000;
        reset_to(12'hFFF);
        rst_n = 1'b1;
        wait_halt();
        chk("R11", "pc wrapped", 32'(pc_o), 32'h0);
        chk("R11", "acc unchanged", 32'(acc_o), 32'h0);

        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
        end
        $finish;
    end
endmodule